// File: doc/BRIEF.md
# Modulo 2^k-1 Prefix Adder

This block adds two residues modulo 2^k-1 in a single combinational path and returns one canonical result between 0 and 2^k-2. A plain k-bit binary sum is formed first, using bitwise generate and propagate terms, a logarithmic-depth prefix tree and a sum stage. A separate wrap-correction stage then adds one to that sum when the tree shows that the true total reached or passed the modulus. The carry out of that increment is dropped, so the all-ones pattern, which is the second form of zero, never reaches the output.

The correction decision comes straight from the tree's final group terms, so no second addition and no extra prefix level is needed. The block is meant for residue-arithmetic channels and for the summing stages of residue-to-binary converters. It has no clock and no state, and the result follows the operands within the same cycle.

Top module: `modm1_prefix_adder`

## Requirements
- R1: For operands in 0..2^k-2, `sumMod` equals (opA + opB) mod (2^k-1) as an unsigned k-bit value.
- R2: When both operands are in 0..2^k-2, `sumMod` is never all ones. Zero is always given as all zeros.
- R3: When opA + opB equals exactly 2^k-1, `sumMod` is 0.
- R4: With opA = opB = 0, `sumMod` is 0.
- R5: With opA = opB = 2^k-2, `sumMod` is 2^k-3.
- R6: When opA + opB is below 2^k-1, `sumMod` is the plain binary sum. When opA + opB is 2^k-1 or more, `sumMod` is that sum minus 2^k-1. The increment is applied exactly when the total is at least 2^k-1.
- R7: Swapping the two operands leaves `sumMod` unchanged.
- R8: The block is purely combinational, so `sumMod` reflects the present operands in the same cycle they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | K | First residue, expected in 0..2^K-2 |
| opB | input | K | Second residue, expected in 0..2^K-2 |
| sumMod | output | K | Canonical sum modulo 2^K-1 |

## Verification
The assertions assume that both operands are already reduced, meaning neither one is the all-ones pattern. The single-zero and modular-sum checks are therefore gated on that condition, and an unreduced input simply skips them. The stimulus respects the same assumption. The exhaustive sweep at K=8 stops at 2^8-2. The random vectors at K=16 are drawn by $urandom modulo 2^16-1, and the directed corner values are chosen inside that range.

// File: rtl/modm1_pkg.sv
package modm1_pkg;

  // Strobes sent from the wrap-correction control to the datapath.
  typedef struct packed {
    logic incEn;      // add one to the raw binary sum
    logic exactWrap;  // total equals the modulus exactly
  } corrStrobes_t;

endpackage

// File: rtl/modm1_kstone_tree.sv
// Kogge-Stone prefix tree with no carry-in.
// gOut[i] is the group generate over bits i..0.
// pAll is the group propagate over every bit.
module modm1_kstone_tree #(
  parameter int K = 8
) (
  input  logic [K-1:0] gIn,
  input  logic [K-1:0] pIn,
  output logic [K-1:0] gOut,
  output logic         pAll
);
  localparam int LV = (K > 1) ? $clog2(K) : 1;

  logic [K-1:0] gLvl [0:LV];
  logic [K-1:0] pLvl [0:LV];

  assign gLvl[0] = gIn;
  assign pLvl[0] = pIn;

  for (genvar s = 0; s < LV; s++) begin : g_stage
    localparam int D = 1 << s;
    for (genvar i = 0; i < K; i++) begin : g_bit
      if (i < D) begin : g_buf
        // Buffer cell: this span already reaches bit 0.
        assign gLvl[s+1][i] = gLvl[s][i];
        assign pLvl[s+1][i] = pLvl[s][i];
      end else if ((i < 2 * D) && (((K - 1 - i) % (2 * D)) != 0)) begin : g_gray
        // Gray cell: the span now reaches bit 0 and its propagate
        // feeds nothing further along the path to pAll.
        assign gLvl[s+1][i] = gLvl[s][i] | (pLvl[s][i] & gLvl[s][i-D]);
        assign pLvl[s+1][i] = 1'b0;
      end else begin : g_black
        // Black cell: both group generate and group propagate.
        assign gLvl[s+1][i] = gLvl[s][i] | (pLvl[s][i] & gLvl[s][i-D]);
        assign pLvl[s+1][i] = pLvl[s][i] & pLvl[s][i-D];
      end
    end
  end

  assign gOut = gLvl[LV];
  assign pAll = pLvl[LV][K-1];

  // R6: a carry out of the top bit and an all-propagate total cannot
  // both be present.
  always_comb begin
    p_gen_prop_exclusive_r6: assert (!(gOut[K-1] && pAll))
      else $error("R6: group generate and group propagate both set");
  end
endmodule

// File: rtl/modm1_excess_one.sv
// Conditional increment: adds inc to raw and drops the carry out.
// The bits to toggle come from a prefix-AND scan of the raw sum.
module modm1_excess_one #(
  parameter int K = 8
) (
  input  logic [K-1:0] raw,
  input  logic         inc,
  output logic [K-1:0] res
);
  localparam int LV = (K > 1) ? $clog2(K) : 1;

  logic [K-1:0] aLvl [0:LV];
  logic [K-1:0] toggle;

  assign aLvl[0] = raw;

  for (genvar s = 0; s < LV; s++) begin : g_scan
    localparam int D = 1 << s;
    for (genvar i = 0; i < K; i++) begin : g_bit
      if (i < D) begin : g_pass
        assign aLvl[s+1][i] = aLvl[s][i];
      end else begin : g_and
        assign aLvl[s+1][i] = aLvl[s][i] & aLvl[s][i-D];
      end
    end
  end

  // Bit i toggles when every raw bit below it is one.
  assign toggle = {aLvl[LV][K-2:0], 1'b1};
  assign res    = raw ^ ({K{inc}} & toggle);

  // R6: with no increment requested, the raw sum passes unchanged.
  always_comb begin
    p_pass_when_idle_r6: assert (inc || (res == raw))
      else $error("R6: result differs from raw sum without increment");
  end
endmodule

// File: rtl/modm1_wrap_ctrl.sv
// Turns the tree's final group terms into correction strobes.
module modm1_wrap_ctrl
  import modm1_pkg::*;
(
  input  logic         carryOut,
  input  logic         allProp,
  output corrStrobes_t strobes
);
  always_comb begin
    strobes.incEn     = carryOut | allProp;
    strobes.exactWrap = allProp;
  end
endmodule

// File: rtl/modm1_datapath.sv
// Preprocessing, prefix tree, sum stage and wrap increment.
module modm1_datapath
  import modm1_pkg::*;
#(
  parameter int K = 8
) (
  input  logic [K-1:0] opA,
  input  logic [K-1:0] opB,
  input  corrStrobes_t strobes,
  output logic         carryOut,
  output logic         allProp,
  output logic [K-1:0] sumMod
);
  logic [K-1:0] gBit;
  logic [K-1:0] pBit;
  logic [K-1:0] grpG;
  logic [K-1:0] carryIn;
  logic [K-1:0] rawSum;

  assign gBit = opA & opB;
  assign pBit = opA ^ opB;

  modm1_kstone_tree #(.K(K)) uTree (
    .gIn  (gBit),
    .pIn  (pBit),
    .gOut (grpG),
    .pAll (allProp)
  );

  assign carryIn  = {grpG[K-2:0], 1'b0};
  assign rawSum   = pBit ^ carryIn;
  assign carryOut = grpG[K-1];

  modm1_excess_one #(.K(K)) uInc (
    .raw (rawSum),
    .inc (strobes.incEn),
    .res (sumMod)
  );

  // R3: a total equal to the modulus gives all-ones raw, then zero.
  always_comb begin
    p_exact_wrap_zero_r3: assert (!strobes.exactWrap || ((&rawSum) && (sumMod == '0)))
      else $error("R3: exact wrap did not collapse to zero");
  end
endmodule

// File: rtl/modm1_prefix_adder.sv
// Top: modulo 2^K-1 adder with a single zero representation.
module modm1_prefix_adder
  import modm1_pkg::*;
#(
  parameter int K = 8
) (
  input  logic [K-1:0] opA,
  input  logic [K-1:0] opB,
  output logic [K-1:0] sumMod
);
  localparam logic [K-1:0] ALL_ONES = {K{1'b1}};
  localparam logic [K:0]   MODULUS  = {1'b0, ALL_ONES};

  corrStrobes_t strobes;
  logic         carryOut;
  logic         allProp;

  modm1_wrap_ctrl uCtrl (
    .carryOut (carryOut),
    .allProp  (allProp),
    .strobes  (strobes)
  );

  modm1_datapath #(.K(K)) uDp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .carryOut (carryOut),
    .allProp  (allProp),
    .sumMod   (sumMod)
  );

  logic [K:0] wideSum;
  logic       reduced;
  assign wideSum = {1'b0, opA} + {1'b0, opB};
  assign reduced = (opA != ALL_ONES) && (opB != ALL_ONES);

  always_comb begin
    // R2: the all-ones form of zero never leaves the block.
    p_single_zero_r2: assert (!reduced || (sumMod != ALL_ONES))
      else $error("R2: all-ones result");
    // R6: increment raised exactly when the total reaches the modulus.
    p_inc_decision_r6: assert (strobes.incEn == (wideSum >= MODULUS))
      else $error("R6: wrong increment decision");
    // R1: result matches the modular sum of reduced operands.
    p_mod_sum_r1: assert (!reduced || ({1'b0, sumMod} == ((wideSum >= MODULUS) ? (wideSum - MODULUS) : wideSum)))
      else $error("R1: modular sum mismatch");
  end
endmodule

// File: tb/sim_modm1_prefix_adder.sv
`timescale 1ns/1ps
module sim_modm1_prefix_adder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [7:0]  a8,  b8,  y8;
  logic [15:0] a16, b16, y16;

  modm1_prefix_adder #(.K(8))  u0 (.opA(a8),  .opB(b8),  .sumMod(y8));
  modm1_prefix_adder #(.K(16)) u1 (.opA(a16), .opB(b16), .sumMod(y16));

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  function automatic int expMod(input int a, input int b, input int k);
    int m;
    m = (1 << k) - 1;
    return (a + b) % m;
  endfunction

  task automatic cmp(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run8(input int a, input int b, input string req);
    @(posedge clk);
    a8 = a[7:0]; b8 = b[7:0];
    @(negedge clk);
    cmp(req, int'(y8), expMod(a, b, 8));
  endtask

  task automatic run16(input int a, input int b, input string req);
    @(posedge clk);
    a16 = a[15:0]; b16 = b[15:0];
    @(negedge clk);
    cmp(req, int'(y16), expMod(a, b, 16));
  endtask

  initial begin
    int seed;
    int ra, rb, keep;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    a8 = '0; b8 = '0; a16 = '0; b16 = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4: zero operands at start-up give zero.
    cmp("R4", int'(y8), 0);
    cmp("R4", int'(y16), 0);

    // Directed corners.
    run8(0, 0, "R4");
    run8(100, 155, "R3");
    run8(254, 254, "R5");
    cmp("R5", int'(y8), 253);
    run16(0, 0, "R4");
    run16(65534, 1, "R3");
    cmp("R3", int'(y16), 0);
    run16(65534, 65534, "R5");
    cmp("R5", int'(y16), 65533);
    run16(40000, 25535, "R3");

    // R1/R2/R6/R8: exhaustive sweep at K=8.
    for (int a = 0; a < 255; a++) begin
      for (int b = 0; b < 255; b++) begin
        run8(a, b, (a + b == 255) ? "R3" : "R1");
        nChecks++;
        if (y8 == 8'hFF) begin
          nFails++;
          $display("FAIL R2: actual=%0d expected=not 255", y8);
        end
        if (a + b < 255) cmp("R6", int'(y8), a + b);
        else cmp("R6", int'(y8), a + b - 255);
      end
    end

    // R1/R7: random vectors at K=16, operands then swapped.
    for (int n = 0; n < 20000; n++) begin
      ra = int'($urandom % 65535);
      rb = int'($urandom % 65535);
      run16(ra, rb, "R1");
      keep = int'(y16);
      nChecks++;
      if (y16 == 16'hFFFF) begin
        nFails++;
        $display("FAIL R2: actual=%0d expected=not 65535", y16);
      end
      run16(rb, ra, "R7");
      cmp("R7", int'(y16), keep);
    end

    // R8: result follows a change of operands within the same cycle.
    @(posedge clk);
    a8 = 8'd10; b8 = 8'd20;
    #1;
    cmp("R8", int'(y8), 30);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule